// File: doc/BRIEF.md
# Calibratable PWM Channel Generator

This block produces the on-request for one output channel of a power switch. The request comes from a direct input pin, from a static on-bit, or from an 8-bit pulse-width modulator. One switching period of the modulator is 256 base ticks. The base tick comes from one of two sources. The first is an internal divider, whose period a host can calibrate by timing a chip-select low pulse. The second is an external clock, whose edge spacing the block watches continuously.

To calibrate, the host issues a calibration command strobe and then holds chip select low for a number of system clocks. That count becomes the new internal base period, provided it falls inside a valid window. A count outside the window leaves the current period in place, and the reset default stays in force until a valid calibration arrives.

When the external clock leaves its allowed range, the block does three things: it stops using that clock, it raises a sticky clock-fail flag and a fault request, and it lets the on-bit alone decide the PWM contribution. The flag clears only when the host acknowledges it while the clock is back in range. All pins are plain level or strobe signals and there is no streaming interface. Several instances that share one external clock stay in phase if their PWM enables rise in the same cycle.

Top module: `pwm_channel_gen`

## Requirements
- R1: on_req = (din AND din_gate) OR (on_bit AND pwm_hi AND pwm_en) OR (on_bit AND NOT pwm_en), where pwm_hi is the modulator state. on_req is combinational from these inputs and the block state, and it is 0 after reset when all inputs are 0.
- R2: With pwm_en=1, on_bit=1, din_gate=0 and a steady base period of B clocks, the modulator is high for the first duty of every 256 base ticks. Each high run therefore lasts duty*B clocks, any window of 256*B clocks holds duty*B high clocks, and duty=0 gives no high clocks.
- R3: After reset the internal base period is DEF_PERIOD system clocks (default 4), so one PWM period is 256*DEF_PERIOD clocks.
- R4: After a one-cycle cal_cmd strobe, the next cs_n low pulse is measured as the number N of rising clk edges at which cs_n is sampled low. If CAL_MIN <= N <= CAL_MAX (defaults 2 and 40), the internal base period becomes N clocks.
- R5: A cs_n pulse with N < CAL_MIN or N > CAL_MAX leaves the base period unchanged. So does any cs_n pulse that is not preceded by a cal_cmd strobe.
- R6: With clk_sel_ext=1 and clk_fail=0, each rising edge of ext_clk (after SYNC_STAGES synchronizer flops) is one base tick.
- R7: If clk_sel_ext=1 and the spacing between synchronized ext_clk rising edges is below EXT_MIN, or above EXT_MAX, system clocks (defaults 4 and 20), or no edge arrives for more than EXT_MAX clocks, then clk_fail and fault_req go to 1. While clk_sel_ext=1 and clk_fail=1, on_req = (din AND din_gate) OR on_bit.
- R8: clk_fail stays set until fail_ack is pulsed while the most recent edge spacing was in range and no timeout has occurred since then. An acknowledge while the clock is still out of range has no effect.
- R9: While pwm_en=0 the period counter is held at its start. Instances sharing ext_clk whose pwm_en rise in the same cycle produce identical on_req for equal settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Direct control input |
| on_bit | input | 1 | Static on request |
| pwm_en | input | 1 | Modulator enable; low holds the period counter at start |
| din_gate | input | 1 | Lets din reach on_req when 1 |
| duty | input | DUTY_W | Duty value, high ticks per 256 |
| clk_sel_ext | input | 1 | 1 selects ext_clk as base tick source |
| ext_clk | input | 1 | External base clock (asynchronous) |
| cs_n | input | 1 | Chip select, low pulse timed for calibration |
| cal_cmd | input | 1 | One-cycle strobe arming calibration |
| fail_ack | input | 1 | One-cycle strobe acknowledging clk_fail |
| on_req | output | 1 | Channel on-request |
| clk_fail | output | 1 | Sticky external-clock fault flag |
| fault_req | output | 1 | Fault request raised with clk_fail |

## Verification
The bound checker checks, on every cycle, the logical relations of the on-request: the direct path forcing on, the absence of any request without on_bit or direct drive, static on with the modulator disabled, and the static fallback while the clock fault is set. It also checks that the fault flag stays set until acknowledged and is raised only when the external source is selected. Quantities measured over time can only be shown by bench scenarios: run lengths under the default and calibrated periods, rejection of out-of-window and unarmed pulses, detection of a stopped or too-fast external clock, recovery after acknowledge, and phase alignment of two instances.

// File: rtl/pwm_ch_pkg.sv
package pwm_ch_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE  = 2'd0,
    CAL_ARMED = 2'd1,
    CAL_MEAS  = 2'd2
  } cal_state_e;
endpackage

// File: rtl/pwm_cal_timer.sv
// Internal base tick whose period is set by timing a chip-select low pulse.
module pwm_cal_timer
  import pwm_ch_pkg::*;
#(
  parameter int unsigned DEF_PERIOD = 4,
  parameter int unsigned CAL_MIN    = 2,
  parameter int unsigned CAL_MAX    = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_cmd,
  input  logic cs_n,
  output logic tick
);
  localparam int unsigned PER_W = $clog2(CAL_MAX + 2);
  localparam logic [PER_W-1:0] MIN_V = PER_W'(CAL_MIN);
  localparam logic [PER_W-1:0] MAX_V = PER_W'(CAL_MAX);
  localparam logic [PER_W-1:0] SAT_V = PER_W'(CAL_MAX + 1);
  localparam logic [PER_W-1:0] DEF_V = PER_W'(DEF_PERIOD);
  localparam logic [PER_W-1:0] ONE_V = PER_W'(1);

  cal_state_e       state;
  logic             cs_q;
  logic [PER_W-1:0] meas;
  logic [PER_W-1:0] base;
  logic [PER_W-1:0] tcnt;
  logic             cs_fall;
  logic             cs_rise;

  assign cs_fall = cs_q & ~cs_n;
  assign cs_rise = ~cs_q & cs_n;

  // Pulse measurement and period update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CAL_IDLE;
      cs_q  <= 1'b1;
      meas  <= '0;
      base  <= DEF_V;
    end else begin
      cs_q <= cs_n;
      if (cal_cmd) begin
        state <= CAL_ARMED;
      end else begin
        case (state)
          CAL_ARMED: begin
            if (cs_fall) begin
              meas  <= ONE_V;
              state <= CAL_MEAS;
            end
          end
          CAL_MEAS: begin
            if (cs_rise) begin
              if (meas >= MIN_V && meas <= MAX_V) base <= meas;
              state <= CAL_IDLE;
            end else if (meas != SAT_V) begin
              meas <= meas + ONE_V;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Free-running divider producing one tick every base clocks
  assign tick = (tcnt >= base - ONE_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tcnt <= '0;
    else if (tick) tcnt <= '0;
    else           tcnt <= tcnt + ONE_V;
  end
endmodule

// File: rtl/pwm_ext_mon.sv
// Synchronizes the external clock, checks its edge spacing and holds the fault flag.
module pwm_ext_mon #(
  parameter int unsigned EXT_MIN     = 4,
  parameter int unsigned EXT_MAX     = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic clk_sel_ext,
  input  logic fail_ack,
  output logic ext_tick,
  output logic clk_fail
);
  localparam int unsigned GAP_W = $clog2(EXT_MAX + 2);
  localparam logic [GAP_W-1:0] MIN_V = GAP_W'(EXT_MIN);
  localparam logic [GAP_W-1:0] MAX_V = GAP_W'(EXT_MAX);
  localparam logic [GAP_W-1:0] SAT_V = GAP_W'(EXT_MAX + 1);
  localparam logic [GAP_W-1:0] ONE_V = GAP_W'(1);

  // Synchronizer chain plus one extra flop for edge detection
  for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_sync
    logic q;
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= ext_clk;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= g_sync[i-1].q;
      end
    end
  end

  logic             rise;
  logic [GAP_W-1:0] gap;
  logic             ok_now;
  logic             out_rng;
  logic             bad;

  assign rise    = g_sync[SYNC_STAGES-1].q & ~g_sync[SYNC_STAGES].q;
  assign out_rng = (gap < MIN_V) || (gap > MAX_V);
  assign bad     = rise ? out_rng : (gap > MAX_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap      <= '0;
      ok_now   <= 1'b0;
      clk_fail <= 1'b0;
    end else begin
      if (rise)             gap <= ONE_V;
      else if (gap != SAT_V) gap <= gap + ONE_V;

      if (bad)       ok_now <= 1'b0;
      else if (rise) ok_now <= 1'b1;

      if (bad && clk_sel_ext)       clk_fail <= 1'b1;
      else if (fail_ack && ok_now)  clk_fail <= 1'b0;
    end
  end

  assign ext_tick = rise & ~clk_fail;
endmodule

// File: rtl/pwm_core.sv
// 256-tick period counter and on-request combination.
module pwm_core #(
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pwm_en,
  input  logic [DUTY_W-1:0] duty,
  input  logic              din,
  input  logic              din_gate,
  input  logic              on_bit,
  input  logic              static_mode,
  output logic              on_req
);
  logic [DUTY_W-1:0] cnt;
  logic              pwm_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!pwm_en) cnt <= '0;
    else if (tick)    cnt <= cnt + DUTY_W'(1);
  end

  assign pwm_hi = (cnt < duty);
  assign on_req = (din & din_gate) | (on_bit & (static_mode | ~pwm_en | pwm_hi));
endmodule

// File: rtl/pwm_channel_gen.sv
module pwm_channel_gen #(
  parameter int unsigned DUTY_W      = 8,
  parameter int unsigned DEF_PERIOD  = 4,
  parameter int unsigned CAL_MIN     = 2,
  parameter int unsigned CAL_MAX     = 40,
  parameter int unsigned EXT_MIN     = 4,
  parameter int unsigned EXT_MAX     = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              on_bit,
  input  logic              pwm_en,
  input  logic              din_gate,
  input  logic [DUTY_W-1:0] duty,
  input  logic              clk_sel_ext,
  input  logic              ext_clk,
  input  logic              cs_n,
  input  logic              cal_cmd,
  input  logic              fail_ack,
  output logic              on_req,
  output logic              clk_fail,
  output logic              fault_req
);
  logic int_tick;
  logic ext_tick;
  logic base_tick;
  logic static_mode;

  pwm_cal_timer #(
    .DEF_PERIOD(DEF_PERIOD),
    .CAL_MIN   (CAL_MIN),
    .CAL_MAX   (CAL_MAX)
  ) u_cal (
    .clk    (clk),
    .rst_n  (rst_n),
    .cal_cmd(cal_cmd),
    .cs_n   (cs_n),
    .tick   (int_tick)
  );

  pwm_ext_mon #(
    .EXT_MIN    (EXT_MIN),
    .EXT_MAX    (EXT_MAX),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_clk    (ext_clk),
    .clk_sel_ext(clk_sel_ext),
    .fail_ack   (fail_ack),
    .ext_tick   (ext_tick),
    .clk_fail   (clk_fail)
  );

  assign base_tick   = clk_sel_ext ? ext_tick : int_tick;
  assign static_mode = clk_sel_ext & clk_fail;
  assign fault_req   = clk_fail;

  pwm_core #(
    .DUTY_W(DUTY_W)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (base_tick),
    .pwm_en     (pwm_en),
    .duty       (duty),
    .din        (din),
    .din_gate   (din_gate),
    .on_bit     (on_bit),
    .static_mode(static_mode),
    .on_req     (on_req)
  );
endmodule

// File: rtl/pwm_channel_gen_chk.sv
module pwm_channel_gen_chk #(
  parameter int unsigned DUTY_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              din,
  input logic              on_bit,
  input logic              pwm_en,
  input logic              din_gate,
  input logic [DUTY_W-1:0] duty,
  input logic              clk_sel_ext,
  input logic              ext_clk,
  input logic              cs_n,
  input logic              cal_cmd,
  input logic              fail_ack,
  input logic              on_req,
  input logic              clk_fail,
  input logic              fault_req
);
  AST_DIRECT_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (din && din_gate) |-> on_req); // R1
  AST_NO_SOURCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_bit && !(din && din_gate)) |-> !on_req); // R1
  AST_STATIC_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (on_bit && !pwm_en) |-> on_req); // R1
  AST_FALLBACK_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_ext && clk_fail && on_bit) |-> on_req); // R7
  AST_FAIL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_fail) |-> $past(clk_sel_ext)); // R7
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_fail && !fail_ack) |=> clk_fail); // R8
endmodule

bind pwm_channel_gen pwm_channel_gen_chk #(.DUTY_W(DUTY_W)) u_chk (.*);

// File: tb/pwm_channel_gen_tb.sv
module pwm_channel_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       din = 1'b0, on_bit = 1'b0, pwm_en = 1'b0, pwm_en_b = 1'b0;
  logic       din_gate = 1'b0, clk_sel_ext = 1'b0, ext_clk = 1'b0;
  logic       cs_n = 1'b1, cal_cmd = 1'b0, fail_ack = 1'b0;
  logic [7:0] duty = 8'd0;
  logic       on_req, clk_fail, fault_req, on_req_b, clk_fail_b, fault_req_b;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;
  bit         ext_run = 1'b1;
  int         ext_half = 5;

  always #10 clk = ~clk;

  pwm_channel_gen u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .on_bit(on_bit), .pwm_en(pwm_en),
    .din_gate(din_gate), .duty(duty), .clk_sel_ext(clk_sel_ext), .ext_clk(ext_clk),
    .cs_n(cs_n), .cal_cmd(cal_cmd), .fail_ack(fail_ack),
    .on_req(on_req), .clk_fail(clk_fail), .fault_req(fault_req));

  pwm_channel_gen u_dut_b (
    .clk(clk), .rst_n(rst_n), .din(din), .on_bit(on_bit), .pwm_en(pwm_en_b),
    .din_gate(din_gate), .duty(duty), .clk_sel_ext(clk_sel_ext), .ext_clk(ext_clk),
    .cs_n(cs_n), .cal_cmd(cal_cmd), .fail_ack(fail_ack),
    .on_req(on_req_b), .clk_fail(clk_fail_b), .fault_req(fault_req_b));

  // External clock source, half period in system clocks
  always begin
    if (ext_run) begin
      ext_clk = ~ext_clk;
      repeat (ext_half) @(negedge clk);
    end else begin
      @(negedge clk);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Length in clocks of the next complete high run of on_req
  task automatic measure_run(output int len);
    int guard = 0;
    while (on_req !== 1'b0 && guard < 8000) begin @(negedge clk); guard++; end
    while (on_req !== 1'b1 && guard < 8000) begin @(negedge clk); guard++; end
    len = 0;
    while (on_req === 1'b1 && len < 8000) begin len++; @(negedge clk); end
  endtask

  task automatic cal_pulse(input bit arm, input int n);
    if (arm) begin
      @(negedge clk) cal_cmd = 1'b1;
      @(negedge clk) cal_cmd = 1'b0;
    end
    @(negedge clk) cs_n = 1'b0;
    repeat (n) @(negedge clk);
    cs_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic ack();
    @(negedge clk) fail_ack = 1'b1;
    @(negedge clk) fail_ack = 1'b0;
    wait_cyc(1);
  endtask

  task automatic t_reset();
    wait_cyc(1);
    check("R1", "reset on_req", on_req, 0);
    check("R7", "reset clk_fail", clk_fail, 0);
    check("R7", "reset fault_req", fault_req, 0);
  endtask

  task automatic t_direct();
    @(negedge clk) begin din = 1'b1; din_gate = 1'b1; on_bit = 1'b0; end
    wait_cyc(1);
    check("R1", "direct gated on", on_req, 1);
    @(negedge clk) din_gate = 1'b0;
    wait_cyc(1);
    check("R1", "direct blocked", on_req, 0);
    @(negedge clk) begin din = 1'b0; on_bit = 1'b1; pwm_en = 1'b0; end
    wait_cyc(1);
    check("R1", "on_bit without pwm", on_req, 1);
  endtask

  task automatic t_default_pwm();
    int len, hi;
    @(negedge clk) begin duty = 8'd10; pwm_en = 1'b1; end
    measure_run(len);
    check("R3", "default run duty10", len, 40);
    @(negedge clk) duty = 8'd128;
    wait_cyc(1100);
    hi = 0;
    for (int i = 0; i < 1024; i++) begin @(negedge clk); if (on_req) hi++; end
    check("R2", "duty128 highs per period", hi, 512);
    @(negedge clk) duty = 8'd0;
    hi = 0;
    for (int i = 0; i < 1100; i++) begin @(negedge clk); if (on_req) hi++; end
    check("R2", "duty0 highs", hi, 0);
    @(negedge clk) duty = 8'd10;
  endtask

  task automatic t_calibrate();
    int len;
    cal_pulse(1'b1, 8);
    measure_run(len);
    check("R4", "run after cal 8", len, 80);
    cal_pulse(1'b0, 9);
    measure_run(len);
    check("R5", "unarmed pulse ignored", len, 80);
    cal_pulse(1'b1, 1);
    measure_run(len);
    check("R5", "short pulse ignored", len, 80);
    cal_pulse(1'b1, 50);
    measure_run(len);
    check("R5", "long pulse ignored", len, 80);
    cal_pulse(1'b1, 3);
    measure_run(len);
    check("R4", "run after cal 3", len, 30);
  endtask

  task automatic t_ext();
    int len, hi;
    @(negedge clk) clk_sel_ext = 1'b1;
    measure_run(len);
    check("R6", "ext run duty10", len, 100);
    check("R7", "no fail in range", clk_fail, 0);
    ext_run = 1'b0;
    wait_cyc(40);
    check("R7", "stopped clk_fail", clk_fail, 1);
    check("R7", "stopped fault_req", fault_req, 1);
    hi = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (on_req) hi++; end
    check("R7", "static on in fallback", hi, 50);
    @(negedge clk) on_bit = 1'b0;
    wait_cyc(1);
    check("R7", "static off in fallback", on_req, 0);
    @(negedge clk) on_bit = 1'b1;
    ack();
    check("R8", "ack while stopped ignored", clk_fail, 1);
    ext_run = 1'b1;
    wait_cyc(60);
    check("R8", "held without ack", clk_fail, 1);
    ack();
    check("R8", "cleared by ack in range", clk_fail, 0);
    check("R8", "fault_req cleared", fault_req, 0);
    measure_run(len);
    check("R6", "ext run after recovery", len, 100);
    ext_half = 1;
    wait_cyc(30);
    check("R7", "fast clock fail", clk_fail, 1);
    ext_half = 5;
    wait_cyc(60);
    ack();
    check("R8", "recovered from fast", clk_fail, 0);
  endtask

  task automatic t_sync();
    int mism = 0, rises = 0;
    logic prev;
    @(negedge clk) begin duty = 8'd30; pwm_en = 1'b0; pwm_en_b = 1'b1; end
    wait_cyc(333);
    @(negedge clk) pwm_en_b = 1'b0;
    wait_cyc(5);
    @(negedge clk) begin pwm_en = 1'b1; pwm_en_b = 1'b1; end
    @(negedge clk);
    check("R9", "high at period start", on_req, 1);
    prev = on_req;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (on_req !== on_req_b) mism++;
      if (on_req && !prev) rises++;
      prev = on_req;
    end
    check("R9", "channels mismatched cycles", mism, 0);
    check("R9", "periods restarted", (rises > 0) ? 1 : 0, 1);
  endtask

  initial begin
    wait_cyc(3);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_direct();
    t_default_pwm();
    t_calibrate();
    t_ext();
    t_sync();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule